// File: doc/BRIEF.md
# 16-bit Compare Timer with CTC and Fast PWM

This block is a 16-bit up-counter that drives one waveform output and three sticky event flags. A prescaler divides the system clock by one of five factors, and each resulting timer tick advances the count. Four operating modes choose how the count restarts and where its upper limit (TOP) comes from. Two modes clear the counter on a compare match (CTC). The other two are single-slope fast PWM modes.

Software configures the timer through a small synchronous write port. The port reaches a compare value, a separate TOP value, a control word and a write-one-to-clear flag register. In the CTC modes the compare value takes effect on the next clock, so a limit written below the running count is missed until the counter wraps. In the PWM modes the compare value is staged and moves into use only at the end of a counting period, so the pulse width never changes in the middle of a period.

Top module: `wavetimer16`

## Requirements
- R1: `presc_sel` values 0, 1, 2, 3 and 4 give one timer tick every 1, 8, 64, 256 and 1024 clocks. Values 5 to 7 behave as 1. The count changes only on a tick.
- R2: The control word (address 2) holds the mode in bits [1:0] and the output action in bits [3:2]. In mode 0 (CTC) TOP is the compare value, and in mode 1 (CTC) TOP is the TOP register (address 1). On a tick where the count equals TOP, the count returns to 0.
- R3: In modes 0 and 1, a write to the compare register (address 0) is used from the next clock. If the new limit is below the count, the counter runs up to 0xFFFF, wraps to 0 and only then matches.
- R4: On each tick, bit 0 (compare flag) sets when the count equals the compare value. Bit 1 (TOP flag) sets when the count equals the TOP register while mode 1 or 2 is selected. Bit 2 (overflow flag) sets when the count rolls from 0xFFFF to 0.
- R5: A flag stays set until a write to address 3 with a one in that flag's bit. Writing zeros leaves the flag unchanged.
- R6: Output action 1 inverts the waveform on every compare match. In CTC this gives a half period of N·(TOP+1) clocks.
- R7: Output action 0 forces the waveform low.
- R8: In mode 2 (fast PWM) TOP is the TOP register, and in mode 3 (fast PWM) TOP is the active compare value. In both modes the count runs from 0 to TOP and then restarts at 0.
- R9: Output action 2 drives the waveform low on a compare match. In PWM modes it also drives the waveform high on the tick that returns the count to 0, and this action wins over a match in the same tick. With N=1 the output is high for C+1 of every TOP+1 clocks.
- R10: Output action 3 is the mirror of action 2. In PWM modes the waveform is high for TOP−C of every TOP+1 clocks.
- R11: In modes 2 and 3, a compare write only loads a staging register. The staged value becomes active on the tick where the count equals TOP.
- R12: Reset clears the count, the waveform, all flags, the compare and TOP registers, and the control word. After reset the timer is in mode 0 with output action 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| presc_sel | input | 3 | Prescaler factor select |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 compare, 1 TOP, 2 control, 3 flag clear |
| wr_data | input | 16 | Write data |
| wave_o | output | 1 | Waveform output |
| flag_cmp_o | output | 1 | Compare-match flag |
| flag_top_o | output | 1 | TOP-register match flag |
| flag_ovf_o | output | 1 | Overflow flag |
| cnt_o | output | 16 | Current count |

## Verification
The bench sweeps the CTC limit from 0 to 7 and every prescaler code, and it checks the toggle half period arithmetically. A counter that clears one tick late or early, or that decodes the prescaler wrongly, shows up as a wrong period. It writes a CTC limit below the running count and expects about 65,000 clocks of silence before the overflow flag and then an exact match 11 ticks later. A design that compares with greater-or-equal would match at once. PWM duty is swept across every compare value, including the full-scale case. A staged compare written mid-period must not move the falling edge, and a design that writes the active register directly fails that check.

// File: rtl/wt_pkg.sv
package wt_pkg;

    localparam int SEL_W  = 3;
    localparam int PDIV_W = 10;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 4;
    localparam int FLAG_N = 3;

    localparam logic [ADDR_W-1:0] ADDR_CMP  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_TOP  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CLR  = 2'd3;

    localparam int FLG_CMP = 0;
    localparam int FLG_TOP = 1;
    localparam int FLG_OVF = 2;

    typedef enum logic [1:0] {
        MODE_CTC_CMP = 2'd0,
        MODE_CTC_TOP = 2'd1,
        MODE_PWM_TOP = 2'd2,
        MODE_PWM_CMP = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        COM_OFF    = 2'd0,
        COM_TOGGLE = 2'd1,
        COM_CLEAR  = 2'd2,
        COM_SET    = 2'd3
    } com_e;

    typedef struct packed {
        com_e  com;
        mode_e mode;
    } ctrl_t;

    typedef struct packed {
        logic tick;
        logic at_top;
        logic at_cmp;
        logic at_max;
    } evt_t;

    function automatic logic [PDIV_W-1:0] presc_limit(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd1:    return PDIV_W'(7);
            3'd2:    return PDIV_W'(63);
            3'd3:    return PDIV_W'(255);
            3'd4:    return PDIV_W'(1023);
            default: return '0;
        endcase
    endfunction

    function automatic logic is_pwm(input mode_e m);
        return (m == MODE_PWM_TOP) || (m == MODE_PWM_CMP);
    endfunction

    function automatic logic top_from_cmp(input mode_e m);
        return (m == MODE_CTC_CMP) || (m == MODE_PWM_CMP);
    endfunction

endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler
    import wt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [PDIV_W-1:0] pcnt;
    logic [PDIV_W-1:0] limit;

    always_comb begin
        limit = presc_limit(sel);
        tick  = (pcnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/wt_regfile.sv
module wt_regfile
    import wt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              load_stage,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  cmp_act,
    output logic [CNT_W-1:0]  top_reg
);

    logic [CNT_W-1:0] cmp_stage;
    logic             wr_cmp;

    assign wr_cmp = wr_en && (wr_addr == ADDR_CMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_stage <= '0;
            top_reg   <= '0;
            ctrl      <= '{com: COM_OFF, mode: MODE_CTC_CMP};
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CMP:  cmp_stage <= wr_data;
                ADDR_TOP:  top_reg   <= wr_data;
                ADDR_CTRL: ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
                default:   ;
            endcase
        end
    end

    // Unbuffered in CTC modes, loaded at TOP in PWM modes.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_act <= '0;
        end else if (!is_pwm(ctrl.mode)) begin
            cmp_act <= wr_cmp ? wr_data : cmp_stage;
        end else if (load_stage) begin
            cmp_act <= cmp_stage;
        end
    end

endmodule

// File: rtl/wt_counter.sv
module wt_counter
    import wt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] top_val,
    input  logic [CNT_W-1:0] cmp_act,
    output logic [CNT_W-1:0] cnt,
    output evt_t             evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_comb begin
        evt.tick   = tick;
        evt.at_top = (cnt == top_val);
        evt.at_cmp = (cnt == cmp_act);
        evt.at_max = (cnt == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (evt.at_top) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wt_outputs.sv
module wt_outputs
    import wt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  evt_t              evt,
    input  ctrl_t             ctrl,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FLAG_N-1:0] clr_bits,
    output logic              wave,
    output logic [FLAG_N-1:0] flags
);

    logic              pwm;
    logic              bottom;
    logic              match;
    logic [FLAG_N-1:0] set_vec;
    logic [FLAG_N-1:0] clr_vec;

    always_comb begin
        pwm    = is_pwm(ctrl.mode);
        bottom = evt.tick && evt.at_top && pwm;
        match  = evt.tick && evt.at_cmp;

        set_vec          = '0;
        set_vec[FLG_CMP] = match;
        set_vec[FLG_TOP] = evt.tick && evt.at_top && !top_from_cmp(ctrl.mode);
        set_vec[FLG_OVF] = evt.tick && evt.at_max;

        clr_vec = (wr_en && (wr_addr == ADDR_CLR)) ? clr_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave <= 1'b0;
        end else begin
            case (ctrl.com)
                COM_OFF:    wave <= 1'b0;
                COM_TOGGLE: if (match) wave <= ~wave;
                COM_CLEAR: begin
                    if (bottom)     wave <= 1'b1;
                    else if (match) wave <= 1'b0;
                end
                COM_SET: begin
                    if (bottom)     wave <= 1'b0;
                    else if (match) wave <= 1'b1;
                end
                default:    wave <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/wavetimer16.sv
module wavetimer16
    import wt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  presc_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              wave_o,
    output logic              flag_cmp_o,
    output logic              flag_top_o,
    output logic              flag_ovf_o,
    output logic [CNT_W-1:0]  cnt_o
);

    logic              tick;
    ctrl_t             ctrl;
    logic [CNT_W-1:0]  cmp_act;
    logic [CNT_W-1:0]  top_reg;
    logic [CNT_W-1:0]  top_val;
    logic [CNT_W-1:0]  cnt;
    evt_t              evt;
    logic [FLAG_N-1:0] flags;

    assign top_val = top_from_cmp(ctrl.mode) ? cmp_act : top_reg;

    wt_prescaler u_presc (
        .clk  (clk),
        .rst  (rst),
        .sel  (presc_sel),
        .tick (tick)
    );

    wt_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .load_stage (evt.tick && evt.at_top),
        .ctrl       (ctrl),
        .cmp_act    (cmp_act),
        .top_reg    (top_reg)
    );

    wt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .top_val (top_val),
        .cmp_act (cmp_act),
        .cnt     (cnt),
        .evt     (evt)
    );

    wt_outputs u_out (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .ctrl     (ctrl),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .clr_bits (wr_data[FLAG_N-1:0]),
        .wave     (wave_o),
        .flags    (flags)
    );

    assign cnt_o      = cnt;
    assign flag_cmp_o = flags[FLG_CMP];
    assign flag_top_o = flags[FLG_TOP];
    assign flag_ovf_o = flags[FLG_OVF];

endmodule

// File: rtl/wavetimer16_checker.sv
module wavetimer16_checker
    import wt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              clr_cmp_bit,
    input logic [CNT_W-1:0]  cnt_o,
    input logic              wave_o,
    input logic              flag_cmp_o,
    input logic              flag_ovf_o,
    input logic              tick,
    input logic [CNT_W-1:0]  top_val,
    input logic [CNT_W-1:0]  cmp_act,
    input ctrl_t             ctrl
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_o));

    assert_top_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_o == top_val) |=> (cnt_o == '0));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_o != top_val) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

    assert_ovf_set_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_o == CNT_MAX) |=> flag_ovf_o);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (flag_cmp_o && !(wr_en && wr_addr == ADDR_CLR && clr_cmp_bit)) |=> flag_cmp_o);

    assert_com_off_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.com == COM_OFF) |=> !wave_o);

    assert_bottom_set_R9: assert property (@(posedge clk) disable iff (rst)
        (is_pwm(ctrl.mode) && ctrl.com == COM_CLEAR && tick && cnt_o == top_val) |=> wave_o);

    assert_stage_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (is_pwm(ctrl.mode) && !(tick && cnt_o == top_val)) |=> $stable(cmp_act));

endmodule

bind wavetimer16 wavetimer16_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .clr_cmp_bit (wr_data[0]),
    .cnt_o       (cnt_o),
    .wave_o      (wave_o),
    .flag_cmp_o  (flag_cmp_o),
    .flag_ovf_o  (flag_ovf_o),
    .tick        (tick),
    .top_val     (top_val),
    .cmp_act     (cmp_act),
    .ctrl        (ctrl)
);

// File: tb/wavetimer16_tb.sv
module wavetimer16_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  presc_sel = 3'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        wave_o, flag_cmp_o, flag_top_o, flag_ovf_o;
    logic [15:0] cnt_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    wavetimer16 u_dut (
        .clk        (clk),
        .rst        (rst),
        .presc_sel  (presc_sel),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wave_o     (wave_o),
        .flag_cmp_o (flag_cmp_o),
        .flag_top_o (flag_top_o),
        .flag_ovf_o (flag_ovf_o),
        .cnt_o      (cnt_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset;
        rst   = 1'b1;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_toggle(output int n);
        logic p;
        p = wave_o;
        n = 0;
        while (wave_o == p && n < 10000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Skips two toggles to settle, then returns the next half period.
    task automatic half_period(output int n);
        int d;
        wait_toggle(d);
        wait_toggle(d);
        wait_toggle(n);
    endtask

    task automatic wait_cnt(input int v);
        int n = 0;
        while (cnt_o != v[15:0] && n < 100000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic max_cnt(input int len, output int m);
        m = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (int'(cnt_o) > m) m = int'(cnt_o);
        end
    endtask

    task automatic high_count(input int len, output int h);
        h = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (wave_o) h++;
        end
    endtask

    initial begin
        int n;
        int m;
        int h;
        int cvals[3];
        int ndiv[6];
        cvals = '{0, 4, 9};
        ndiv  = '{1, 8, 64, 256, 1024, 1};

        // R12: reset state
        repeat (3) @(negedge clk);
        chk("R12 cnt", int'(cnt_o), 0);
        chk("R12 wave", int'(wave_o), 0);
        chk("R12 flags", int'({flag_ovf_o, flag_top_o, flag_cmp_o}), 0);
        rst = 1'b0;

        // R6 / R2: CTC toggle sweep, mode 0, N=1
        wr(2'd2, 16'h0004);
        for (int t = 0; t < 8; t++) begin
            wr(2'd0, 16'(t));
            half_period(n);
            chk($sformatf("R6 toggle half period T=%0d", t), n, t + 1);
        end
        max_cnt(40, m);
        chk("R2 CTC max count T=7", m, 7);

        // R1: prescaler sweep with T=1
        wr(2'd0, 16'd1);
        for (int s = 1; s < 6; s++) begin
            presc_sel = 3'(s);
            half_period(n);
            chk($sformatf("R1 prescaler sel=%0d", s), n, 2 * ndiv[s]);
        end
        presc_sel = 3'd0;

        // R7: output action 0 forces low
        wr(2'd2, 16'h0000);
        repeat (2) @(negedge clk);
        high_count(30, h);
        chk("R7 output off", h, 0);

        // R2 mode 1, R4 / R5 TOP flag
        do_reset;
        wr(2'd1, 16'd20);
        wr(2'd0, 16'd5);
        wr(2'd2, 16'h0005);
        half_period(n);
        chk("R2 mode1 half period", n, 21);
        max_cnt(50, m);
        chk("R2 mode1 max count", m, 20);
        wait_cnt(2);
        wr(2'd3, 16'h0002);
        chk("R5 top flag cleared", int'(flag_top_o), 0);
        chk("R5 cmp flag untouched", int'(flag_cmp_o), 1);
        repeat (25) @(negedge clk);
        chk("R4 top flag set", int'(flag_top_o), 1);

        // R3: immediate write in CTC
        do_reset;
        wr(2'd0, 16'd1000);
        wait_cnt(50);
        wr(2'd3, 16'h0007);
        wr(2'd0, 16'd200);
        max_cnt(400, m);
        chk("R3 immediate limit", m, 200);

        // R3 / R4: limit written below count is missed until wrap
        wait_cnt(150);
        wr(2'd0, 16'd10);
        wr(2'd3, 16'h0007);
        n = 0;
        while (!flag_ovf_o && n < 70000) begin
            @(negedge clk);
            n++;
        end
        chk("R3 match missed until wrap", int'(n > 60000), 1);
        chk("R4 overflow count zero", int'(cnt_o), 0);
        chk("R3 no match before wrap", int'(flag_cmp_o), 0);
        repeat (10) @(negedge clk);
        chk("R3 count reaches limit", int'(cnt_o), 10);
        chk("R3 no match yet", int'(flag_cmp_o), 0);
        @(negedge clk);
        chk("R3 match after wrap", int'(flag_cmp_o), 1);
        chk("R3 cleared after match", int'(cnt_o), 0);

        // R9 / R8: non-inverting fast PWM, TOP register = 9
        do_reset;
        wr(2'd1, 16'd9);
        wr(2'd2, 16'h000A);
        for (int c = 0; c < 10; c++) begin
            wr(2'd0, 16'(c));
            repeat (25) @(negedge clk);
            high_count(10, h);
            chk($sformatf("R9 duty C=%0d", c), h, c + 1);
        end
        max_cnt(20, m);
        chk("R8 mode2 max count", m, 9);

        // R10: inverting fast PWM
        wr(2'd2, 16'h000E);
        for (int i = 0; i < 3; i++) begin
            wr(2'd0, 16'(cvals[i]));
            repeat (25) @(negedge clk);
            high_count(10, h);
            chk($sformatf("R10 duty C=%0d", cvals[i]), h, 9 - cvals[i]);
        end

        // R11: staged compare in PWM
        do_reset;
        wr(2'd1, 16'd999);
        wr(2'd0, 16'd100);
        wr(2'd2, 16'h000A);
        wait_cnt(50);
        wr(2'd0, 16'd800);
        wait_cnt(150);
        chk("R11 old compare still active", int'(wave_o), 0);
        wait_cnt(0);
        wait_cnt(500);
        chk("R11 staged compare loaded at TOP", int'(wave_o), 1);

        // R8: mode 3, compare value is TOP
        do_reset;
        wr(2'd0, 16'd4);
        wr(2'd2, 16'h0007);
        half_period(n);
        chk("R8 mode3 half period", n, 5);
        max_cnt(30, m);
        chk("R8 mode3 max count", m, 4);
        wr(2'd0, 16'd6);
        half_period(n);
        chk("R11 mode3 new TOP", n, 7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
                $finish;
            end
        end
    end

endmodule